// File: doc/BRIEF.md
# Sensorless Boost PFC Current-Rebuilding Modulator

This block drives the switch of a boost power-factor stage that has no current sensor. On every sample strobe it estimates the inductor current by integrating the sampled voltages. While the switch conducts, the current grows with the grid voltage. While the switch is open, it changes with the difference between the grid voltage and the output voltage. The increment is scaled by a programmable gain that stands for the ratio of sample time to inductance.

The rebuilt current is compared with a sawtooth carrier. The carrier restarts at zero every switching period and climbs linearly toward an amplitude word supplied by the outer voltage loop. The switch is turned on at the start of every period. It is turned off on the first sample where the rebuilt current reaches the carrier, and it stays off for the rest of the period. The result is nonlinear-carrier control in which the line current follows the grid voltage without being measured.

The block sits between the converter's sampling front end and the gate driver. The voltage regulator feeds the amplitude word and a constant feeds the gain.

Top module: `pfc_rebuild_modulator`

## Requirements
- R1: A synchronous reset forces the gate output to 0 and the rebuilt current to 0, and places the period counter so that the first strobe after reset is the first sample of a new period. No output changes between reset and that first strobe.
- R2: On a strobe taken while the gate output is 1, the current increment is gridV multiplied by gainTL and shifted right by 12 bits. gridV is signed two's complement, gainTL is unsigned, and the gate value is the one held just before the strobe.
- R3: On a strobe taken while the gate output is 0, the increment is (gridV minus outV) multiplied by gainTL and shifted right by 12 bits. Both voltages are signed two's complement.
- R4: The shifted product is rounded toward zero. For example, -3000 gives 0 and -7000 gives -1, where flooring would give -1 and -2.
- R5: The rebuilt current is unsigned, 16 bits wide, and saturates at 0 from below and at 65535 from above.
- R6: A switching period spans 16 strobes. On the first strobe of each period the gate output becomes 1, whatever the comparison says.
- R7: At sample n of a period (n from 1 to 15), the carrier equals floor(A·n/16). A is the carrierAmp value captured on the first strobe of that period. Changes to carrierAmp later in the period have no effect until the next period.
- R8: On a strobe at sample n ≥ 1, the gate output becomes 0 if the updated current is greater than or equal to the carrier. Once cleared, the gate stays 0 until the next period begins. With an amplitude of 0, the gate is therefore high for exactly one sample per period.
- R9: Both outputs are registered. They change only on the clock edge that samples sampleStb high, and they hold their values on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleStb | input | 1 | One-cycle strobe marking a new voltage sample |
| gridV | input | 16 | Rectified grid voltage sample, signed |
| outV | input | 16 | Output voltage sample, signed |
| carrierAmp | input | 16 | Carrier amplitude from the voltage loop, unsigned |
| gainTL | input | 16 | Sample-time over inductance gain, unsigned, 12 fraction bits |
| gateOut | output | 1 | Switch gate command |
| iRebuilt | output | 16 | Rebuilt inductor current, unsigned |

## Verification
Two events can land on the same strobe. A period restart can arrive on a sample where the rebuilt current already exceeds the carrier, and saturation of the current can arrive on the sample where the comparison clears the gate. The bench provokes the first case by holding large currents across period boundaries with small amplitudes. It provokes the second with full-scale voltages and gain, so that the clamped value is the one compared. A scoreboard model, in which the period restart takes precedence and the clamp is applied before the comparison, predicts both the gate and the current for every strobe.

// File: rtl/pfc_mod_pkg.sv
package pfc_mod_pkg;

  // Strobes passed from the control unit to the datapath
  typedef struct packed {
    logic sampleTick;   // a new sample is being consumed this cycle
    logic periodStart;  // this sample opens a switching period
  } pfcStrobes_t;

endpackage

// File: rtl/pfc_mod_ctrl.sv
module pfc_mod_ctrl
  import pfc_mod_pkg::*;
#(
  parameter int PERIOD_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        sampleStb,
  input  logic        reachedCarrier,
  output pfcStrobes_t strobes,
  output logic        gateOn
);

  localparam logic [PERIOD_LOG2-1:0] LAST_SAMPLE = '1;

  logic [PERIOD_LOG2-1:0] sampleCntQ;
  logic                   gateQ;

  always_comb begin
    strobes.sampleTick  = sampleStb;
    strobes.periodStart = sampleStb && (sampleCntQ == LAST_SAMPLE);
  end

  // Counter parked on the last slot so the first strobe opens a period.
  always_ff @(posedge clk) begin
    if (rst) begin
      sampleCntQ <= LAST_SAMPLE;
      gateQ      <= 1'b0;
    end else if (sampleStb) begin
      sampleCntQ <= sampleCntQ + 1'b1;
      if (strobes.periodStart)
        gateQ <= 1'b1;
      else if (reachedCarrier)
        gateQ <= 1'b0;
    end
  end

  assign gateOn = gateQ;

  // R6: every period opens with the switch on
  assert_gate_on_at_start_R6: assert property (@(posedge clk) disable iff (rst)
    strobes.periodStart |=> gateQ);

  // R8: once off, the gate stays off until a period starts
  assert_gate_stays_off_R8: assert property (@(posedge clk) disable iff (rst)
    (!gateQ && !strobes.periodStart) |=> !gateQ);

  // R9: without a strobe the gate holds
  assert_gate_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !sampleStb |=> $stable(gateQ));

endmodule

// File: rtl/pfc_mod_rebuild.sv
module pfc_mod_rebuild #(
  parameter int SAMPLE_W   = 16,
  parameter int GAIN_W     = 16,
  parameter int GAIN_SHIFT = 12,
  parameter int CUR_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleTick,
  input  logic                       gateOn,
  input  logic signed [SAMPLE_W-1:0] gridV,
  input  logic signed [SAMPLE_W-1:0] outV,
  input  logic        [GAIN_W-1:0]   gainTL,
  output logic        [CUR_W-1:0]    curNext,
  output logic        [CUR_W-1:0]    curQ
);

  localparam int PROD_W = SAMPLE_W + GAIN_W + 2;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [PROD_W-1:0] ROUND_BIAS =
    $signed(PROD_W'((64'd1 << GAIN_SHIFT) - 64'd1));
  localparam logic signed [SUM_W-1:0] CUR_MAX =
    $signed({{(SUM_W-CUR_W){1'b0}}, {CUR_W{1'b1}}});

  logic signed [SAMPLE_W:0]   deltaV;
  logic signed [PROD_W-1:0]   deltaW;
  logic signed [PROD_W-1:0]   gainW;
  logic signed [PROD_W-1:0]   prodW;
  logic signed [PROD_W-1:0]   incrW;
  logic signed [SUM_W-1:0]    sumW;

  always_comb begin
    // Increment source depends on the switch state held before the strobe
    if (gateOn)
      deltaV = {gridV[SAMPLE_W-1], gridV};
    else
      deltaV = {gridV[SAMPLE_W-1], gridV} - {outV[SAMPLE_W-1], outV};
    deltaW = {{(PROD_W-SAMPLE_W-1){deltaV[SAMPLE_W]}}, deltaV};
    gainW  = $signed({{(PROD_W-GAIN_W){1'b0}}, gainTL});
    prodW  = deltaW * gainW;
    // Bias negative products so the arithmetic shift truncates toward zero
    if (prodW[PROD_W-1])
      incrW = (prodW + ROUND_BIAS) >>> GAIN_SHIFT;
    else
      incrW = prodW >>> GAIN_SHIFT;
    sumW = $signed({{(SUM_W-CUR_W){1'b0}}, curQ}) + {incrW[PROD_W-1], incrW};
    if (sumW[SUM_W-1])
      curNext = '0;
    else if (sumW > CUR_MAX)
      curNext = '1;
    else
      curNext = sumW[CUR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      curQ <= '0;
    else if (sampleTick)
      curQ <= curNext;
  end

  // R2: with the switch on and a non-negative grid sample the current cannot fall
  assert_on_rises_R2: assert property (@(posedge clk) disable iff (rst)
    (sampleTick && gateOn && !gridV[SAMPLE_W-1]) |=> (curQ >= $past(curQ)));

  // R3: with the switch off and the output above the grid the current cannot rise
  assert_off_falls_R3: assert property (@(posedge clk) disable iff (rst)
    (sampleTick && !gateOn && (gridV <= outV)) |=> (curQ <= $past(curQ)));

  // R9: the current only moves on a sample
  assert_cur_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !sampleTick |=> $stable(curQ));

endmodule

// File: rtl/pfc_mod_carrier.sv
module pfc_mod_carrier
  import pfc_mod_pkg::*;
#(
  parameter int AMP_W       = 16,
  parameter int PERIOD_LOG2 = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  pfcStrobes_t        strobes,
  input  logic [AMP_W-1:0]   carrierAmp,
  output logic [AMP_W-1:0]   carrierNext
);

  localparam int ACC_W = AMP_W + PERIOD_LOG2;

  logic [AMP_W-1:0] ampHoldQ;
  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] accNext;

  // Accumulating the amplitude each sample yields A*n; the top bits give A*n/N.
  always_comb begin
    if (strobes.periodStart)
      accNext = '0;
    else
      accNext = accQ + {{PERIOD_LOG2{1'b0}}, ampHoldQ};
    carrierNext = accNext[ACC_W-1:PERIOD_LOG2];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ     <= '0;
      ampHoldQ <= '0;
    end else if (strobes.sampleTick) begin
      accQ <= accNext;
      if (strobes.periodStart)
        ampHoldQ <= carrierAmp;
    end
  end

  // R7: the ramp restarts at zero on every period start
  assert_ramp_restart_R7: assert property (@(posedge clk) disable iff (rst)
    strobes.periodStart |=> (accQ == '0));

  // R7: inside a period the ramp never wraps downward
  assert_ramp_monotonic_R7: assert property (@(posedge clk) disable iff (rst)
    (strobes.sampleTick && !strobes.periodStart) |=> (accQ >= $past(accQ)));

endmodule

// File: rtl/pfc_mod_datapath.sv
module pfc_mod_datapath
  import pfc_mod_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int GAIN_W      = 16,
  parameter int GAIN_SHIFT  = 12,
  parameter int CUR_W       = 16,
  parameter int AMP_W       = 16,
  parameter int PERIOD_LOG2 = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  pfcStrobes_t                strobes,
  input  logic                       gateOn,
  input  logic signed [SAMPLE_W-1:0] gridV,
  input  logic signed [SAMPLE_W-1:0] outV,
  input  logic        [AMP_W-1:0]    carrierAmp,
  input  logic        [GAIN_W-1:0]   gainTL,
  output logic                       reachedCarrier,
  output logic        [CUR_W-1:0]    curQ
);

  localparam int CMP_W = (CUR_W > AMP_W) ? CUR_W : AMP_W;

  logic [CUR_W-1:0] curNext;
  logic [AMP_W-1:0] carrierNext;

  pfc_mod_rebuild #(
    .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .GAIN_SHIFT(GAIN_SHIFT), .CUR_W(CUR_W)
  ) rebuild_i (
    .clk(clk), .rst(rst), .sampleTick(strobes.sampleTick), .gateOn(gateOn),
    .gridV(gridV), .outV(outV), .gainTL(gainTL),
    .curNext(curNext), .curQ(curQ)
  );

  pfc_mod_carrier #(
    .AMP_W(AMP_W), .PERIOD_LOG2(PERIOD_LOG2)
  ) carrier_i (
    .clk(clk), .rst(rst), .strobes(strobes), .carrierAmp(carrierAmp),
    .carrierNext(carrierNext)
  );

  // Updated current against updated carrier, both for the sample being consumed
  assign reachedCarrier = CMP_W'(curNext) >= CMP_W'(carrierNext);

endmodule

// File: rtl/pfc_rebuild_modulator.sv
module pfc_rebuild_modulator
  import pfc_mod_pkg::*;
#(
  parameter int SAMPLE_W    = 16,
  parameter int GAIN_W      = 16,
  parameter int GAIN_SHIFT  = 12,
  parameter int CUR_W       = 16,
  parameter int AMP_W       = 16,
  parameter int PERIOD_LOG2 = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sampleStb,
  input  logic signed [SAMPLE_W-1:0] gridV,
  input  logic signed [SAMPLE_W-1:0] outV,
  input  logic        [AMP_W-1:0]    carrierAmp,
  input  logic        [GAIN_W-1:0]   gainTL,
  output logic                       gateOut,
  output logic        [CUR_W-1:0]    iRebuilt
);

  pfcStrobes_t strobes;
  logic        reachedCarrier;
  logic        gateOn;

  pfc_mod_ctrl #(.PERIOD_LOG2(PERIOD_LOG2)) ctrl_i (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .reachedCarrier(reachedCarrier),
    .strobes(strobes), .gateOn(gateOn)
  );

  pfc_mod_datapath #(
    .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .GAIN_SHIFT(GAIN_SHIFT),
    .CUR_W(CUR_W), .AMP_W(AMP_W), .PERIOD_LOG2(PERIOD_LOG2)
  ) datapath_i (
    .clk(clk), .rst(rst), .strobes(strobes), .gateOn(gateOn),
    .gridV(gridV), .outV(outV), .carrierAmp(carrierAmp), .gainTL(gainTL),
    .reachedCarrier(reachedCarrier), .curQ(iRebuilt)
  );

  assign gateOut = gateOn;

  // R1: the first output edge after reset waits for a strobe
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    (rst && !sampleStb) |=> (!gateOut && (iRebuilt == '0)));

endmodule

// File: tb/pfc_rebuild_modulator_tb_top.sv
`timescale 1ns/1ps
module pfc_rebuild_modulator_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleStb = 1'b0;
  logic signed [15:0] gridV = '0;
  logic signed [15:0] outV = '0;
  logic [15:0] carrierAmp = '0;
  logic [15:0] gainTL = '0;
  logic gateOut;
  logic [15:0] iRebuilt;

  always #2.5 clk = ~clk;

  pfc_rebuild_modulator dut_i (
    .clk(clk), .rst(rst), .sampleStb(sampleStb), .gridV(gridV), .outV(outV),
    .carrierAmp(carrierAmp), .gainTL(gainTL), .gateOut(gateOut), .iRebuilt(iRebuilt)
  );

  typedef struct {
    logic        gate;
    logic [15:0] cur;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model state
  longint mCur;
  int     mCnt;
  longint mAcc;
  longint mAmp;
  bit     mGate;

  task automatic modelReset();
    mCur = 0; mCnt = 15; mAcc = 0; mAmp = 0; mGate = 0;
  endtask

  task automatic compare(logic g, logic [15:0] c, logic eg, logic [15:0] ec, string tag);
    checks++;
    if (g !== eg || c !== ec) begin
      fails++;
      $display("FAIL %s: gate=%0d cur=%0d expected gate=%0d cur=%0d", tag, g, c, eg, ec);
    end
  endtask

  // Driver: one strobe, expected result pushed to the scoreboard
  task automatic applySample(int vg, int vo, int amp, int gain, string tag, int idle);
    longint delta, prod, inc, ni, car;
    expItem_t it;
    @(negedge clk);
    gridV = 16'(vg); outV = 16'(vo); carrierAmp = 16'(amp); gainTL = 16'(gain);
    sampleStb = 1'b1;
    delta = mGate ? longint'(vg) : longint'(vg) - longint'(vo);
    prod  = delta * longint'(gain);
    inc   = (prod >= 0) ? (prod >>> 12) : -((-prod) >>> 12);
    ni = mCur + inc;
    if (ni < 0) ni = 0;
    if (ni > 65535) ni = 65535;
    if (mCnt == 15) begin
      mCnt = 0; mAcc = 0; mAmp = longint'(amp); mGate = 1;
    end else begin
      mCnt++; mAcc += mAmp; car = mAcc >>> 4;
      if (ni >= car) mGate = 0;
    end
    mCur = ni;
    it.gate = mGate; it.cur = 16'(mCur); it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    sampleStb = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  // Monitor: compare on the negedge following each sampled strobe
  logic stbSeen = 1'b0;
  always @(posedge clk) stbSeen <= sampleStb && !rst;
  always @(negedge clk) begin
    if (stbSeen && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      compare(gateOut, iRebuilt, e.gate, e.cur, e.tag);
    end
  end

  task automatic doReset();
    @(negedge clk); rst = 1'b1; sampleStb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    modelReset();
    compare(gateOut, iRebuilt, 1'b0, 16'd0, "R1 reset state");
    repeat (4) @(negedge clk);
    compare(gateOut, iRebuilt, 1'b0, 16'd0, "R1 idle before first strobe");
  endtask

  task automatic checkHold(int n);
    logic g0; logic [15:0] c0;
    g0 = gateOut; c0 = iRebuilt;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare(gateOut, iRebuilt, g0, c0, "R9 hold without strobe");
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    modelReset();
    doReset();

    // R2 R3 R6 R8: normal ramps with a varying grid sample, several periods
    for (int i = 0; i < 48; i++)
      applySample(200 + 60 * (i % 8), 700, 20000, 4096, "R2/R3/R8 ramp", i % 3);

    // R6: large current carried into period starts with a small carrier
    for (int i = 0; i < 34; i++)
      applySample(3000, 3100, 500, 4096, "R6 start beats compare", 0);

    // R4: negative products round toward zero
    for (int i = 0; i < 6; i++) applySample(-3, 0, 60000, 1000, "R4 round -3000", 0);
    for (int i = 0; i < 6; i++) applySample(-7, 0, 60000, 1000, "R4 round -7000", 0);
    for (int i = 0; i < 4; i++) applySample(5, 0, 60000, 1000, "R4 round +5000", 0);

    // R5: floor at zero
    for (int i = 0; i < 10; i++) applySample(100, 5000, 30000, 4096, "R5 floor off-state", 0);
    for (int i = 0; i < 6; i++) applySample(-2000, -2000, 30000, 4096, "R5 floor on-state", 0);

    // R5 R8: saturation at top while comparing
    for (int i = 0; i < 20; i++)
      applySample(32767, (i % 2) ? -32768 : 0, 65535, 65535, "R5 ceiling", 0);

    // R8: zero amplitude keeps the gate high for one sample per period
    for (int i = 0; i < 32; i++) applySample(100, 150, 0, 4096, "R8 zero amplitude", 0);

    // R7: amplitude changes inside a period are ignored until the next
    for (int i = 0; i < 32; i++)
      applySample(400, 420, (i % 2) ? 2000 : 40000, 4096, "R7 amplitude latch", 0);

    // R9: outputs hold across idle cycles
    applySample(900, 300, 12000, 4096, "R9 before idle", 0);
    checkHold(5);
    applySample(900, 300, 12000, 4096, "R9 after idle", 0);
    checkHold(3);

    // R1: reset mid-run, then the first strobe opens a fresh period
    doReset();
    for (int i = 0; i < 18; i++) applySample(500, 800, 16000, 4096, "R1 restart", 0);

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R9: %0d results missing, expected 0", expQ.size());
    end
    finishRun();
  end

endmodule